// File: doc/BRIEF.md
# Front-End Command Decoder with Per-Command Delays

This block sits behind the parallel output of the front-end link receiver. On every 40 MHz bunch-clock cycle it takes in a 24-bit timing-and-control word. It splits that word into the individual command strobes a front-end needs: crossing-counter reset, front-end logic reset, header-only, crossing veto, a 4-bit calibration type, non-zero-suppressed readout and snapshot. It also extracts the crossing number that the word belongs to.

The word is sent well ahead of the crossing it describes, roughly sixteen cycles plus the link latency. Each command therefore passes through its own delay, programmable from 0 to 31 cycles, so that it lines up with the crossing the local detector is actually handling. The crossing number travels with the header-only command, so that data tagged with it stays consistent with the header decision.

The two reset strobes are defined as single-cycle pulses. The decoder turns any run of consecutive words that carry a reset bit into one pulse, taken from the first word of the run.

Top module: `fe_cmd_delay`

## Requirements
- R1: Field positions in `i_word`: crossing number in bits 11:0, calibration type in bits 15:12, crossing-counter reset in bit 16, front-end reset in bit 17, header-only in bit 18, veto in bit 19, non-zero-suppressed readout in bit 20, snapshot in bit 21.
- R2: A channel programmed with delay d shows the command of the word sampled at clock edge n on its output just after edge n+d. A delay of 0 therefore gives one register stage of latency.
- R3: `o_xid` carries the crossing number with exactly the delay of the header-only channel.
- R4: A write with `cfg_we`=1 and `cfg_sel` in 0..6 sets the delay of one channel, and that delay is used from the next edge on. The channel order is: 0 crossing-counter reset, 1 front-end reset, 2 header-only, 3 veto, 4 calibration, 5 non-zero-suppressed, 6 snapshot. A value above the maximum is held at the maximum. The timing of the other channels does not change.
- R5: A write with `cfg_sel`=7 changes no delay.
- R6: The two reset outputs are asserted only for the first word of a run of consecutive words that carry the bit, so each run gives a single-cycle pulse.
- R7: While `rst_n` is low, all outputs are 0, all delays are 0 and the delay history is cleared.
- R8: Bits 23:22 of `i_word` have no effect on any output.
- R9: The 4-bit calibration type is delayed as one unit under its own delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_word | input | 24 | Command word, one per cycle |
| cfg_we | input | 1 | Delay register write strobe |
| cfg_sel | input | 3 | Channel selected for the write |
| cfg_val | input | 5 | Delay value in cycles |
| o_xrst | output | 1 | Delayed crossing-counter reset pulse |
| o_frst | output | 1 | Delayed front-end reset pulse |
| o_hdr | output | 1 | Delayed header-only |
| o_veto | output | 1 | Delayed crossing veto |
| o_cal | output | 4 | Delayed calibration type |
| o_nzs | output | 1 | Delayed non-zero-suppressed readout |
| o_snap | output | 1 | Delayed snapshot |
| o_xid | output | 12 | Crossing number, delayed like header-only |

## Verification
A stale or misdirected delay register shows up as a command that lands a fixed number of cycles early or late. It appears on the first command that passes through that channel after the fault, at most 31 cycles later. A corrupted history entry, or a reset-run detector that has lost its state, shows up as a wrong or doubled strobe within one delay period. The crossing number comparison exposes any slip between the header channel and the tag. Comparing every output on every cycle against a queue model, under distinct per-channel delays and mid-stream delay changes, catches each of these within one history length.

// File: rtl/fe_cmd_delay.sv
`timescale 1ns/1ps
module fe_cmd_delay #(
  parameter int XID_W   = 12,
  parameter int CAL_W   = 4,
  parameter int MAX_DLY = 31,
  localparam int NCH    = 7,
  localparam int DW     = $clog2(MAX_DLY + 1),
  localparam int SEL_W  = $clog2(NCH + 1),
  localparam int WORD_W = XID_W + CAL_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] i_word,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DW-1:0]     cfg_val,
  output logic              o_xrst,
  output logic              o_frst,
  output logic              o_hdr,
  output logic              o_veto,
  output logic [CAL_W-1:0]  o_cal,
  output logic              o_nzs,
  output logic              o_snap,
  output logic [XID_W-1:0]  o_xid
);
  localparam int HD     = (MAX_DLY > 0) ? MAX_DLY : 1;
  localparam int B_CAL  = XID_W;
  localparam int B_XRST = XID_W + CAL_W;
  localparam int B_FRST = B_XRST + 1;
  localparam int B_HDR  = B_XRST + 2;
  localparam int B_VETO = B_XRST + 3;
  localparam int B_NZS  = B_XRST + 4;
  localparam int B_SNAP = B_XRST + 5;
  localparam int C_XRST = 0, C_FRST = 1, C_HDR = 2, C_VETO = 3;
  localparam int C_CAL  = 4, C_NZS  = 5, C_SNAP = 6;

  logic [NCH*DW-1:0] dly_q;
  logic p_xrst, p_frst;
  logic unused_spare;

  logic             h_xrst [HD];
  logic             h_frst [HD];
  logic             h_hdr  [HD];
  logic             h_veto [HD];
  logic             h_nzs  [HD];
  logic             h_snap [HD];
  logic [CAL_W-1:0] h_cal  [HD];
  logic [XID_W-1:0] h_xid  [HD];

  assign unused_spare = ^i_word[WORD_W-1:B_SNAP+1];

  wire             c_xrst = i_word[B_XRST] & ~p_xrst;
  wire             c_frst = i_word[B_FRST] & ~p_frst;
  wire             c_hdr  = i_word[B_HDR];
  wire             c_veto = i_word[B_VETO];
  wire             c_nzs  = i_word[B_NZS];
  wire             c_snap = i_word[B_SNAP];
  wire [CAL_W-1:0] c_cal  = i_word[B_CAL +: CAL_W];
  wire [XID_W-1:0] c_xid  = i_word[XID_W-1:0];

  wire [DW-1:0] d_xrst = dly_q[C_XRST*DW +: DW];
  wire [DW-1:0] d_frst = dly_q[C_FRST*DW +: DW];
  wire [DW-1:0] d_hdr  = dly_q[C_HDR*DW  +: DW];
  wire [DW-1:0] d_veto = dly_q[C_VETO*DW +: DW];
  wire [DW-1:0] d_cal  = dly_q[C_CAL*DW  +: DW];
  wire [DW-1:0] d_nzs  = dly_q[C_NZS*DW  +: DW];
  wire [DW-1:0] d_snap = dly_q[C_SNAP*DW +: DW];

  wire [DW-1:0] wr_val = (cfg_val > DW'(MAX_DLY)) ? DW'(MAX_DLY) : cfg_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= '0;
      p_xrst <= 1'b0;
      p_frst <= 1'b0;
    end else begin
      p_xrst <= i_word[B_XRST];
      p_frst <= i_word[B_FRST];
      if (cfg_we && cfg_sel < SEL_W'(NCH))
        dly_q[cfg_sel*DW +: DW] <= wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HD; i++) begin
        h_xrst[i] <= 1'b0;
        h_frst[i] <= 1'b0;
        h_hdr[i]  <= 1'b0;
        h_veto[i] <= 1'b0;
        h_nzs[i]  <= 1'b0;
        h_snap[i] <= 1'b0;
        h_cal[i]  <= '0;
        h_xid[i]  <= '0;
      end
    end else begin
      h_xrst[0] <= c_xrst;
      h_frst[0] <= c_frst;
      h_hdr[0]  <= c_hdr;
      h_veto[0] <= c_veto;
      h_nzs[0]  <= c_nzs;
      h_snap[0] <= c_snap;
      h_cal[0]  <= c_cal;
      h_xid[0]  <= c_xid;
      for (int i = 1; i < HD; i++) begin
        h_xrst[i] <= h_xrst[i-1];
        h_frst[i] <= h_frst[i-1];
        h_hdr[i]  <= h_hdr[i-1];
        h_veto[i] <= h_veto[i-1];
        h_nzs[i]  <= h_nzs[i-1];
        h_snap[i] <= h_snap[i-1];
        h_cal[i]  <= h_cal[i-1];
        h_xid[i]  <= h_xid[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_xrst <= 1'b0;
      o_frst <= 1'b0;
      o_hdr  <= 1'b0;
      o_veto <= 1'b0;
      o_cal  <= '0;
      o_nzs  <= 1'b0;
      o_snap <= 1'b0;
      o_xid  <= '0;
    end else begin
      o_xrst <= (d_xrst == '0) ? c_xrst : h_xrst[d_xrst - 1'b1];
      o_frst <= (d_frst == '0) ? c_frst : h_frst[d_frst - 1'b1];
      o_hdr  <= (d_hdr  == '0) ? c_hdr  : h_hdr[d_hdr - 1'b1];
      o_xid  <= (d_hdr  == '0) ? c_xid  : h_xid[d_hdr - 1'b1];
      o_veto <= (d_veto == '0) ? c_veto : h_veto[d_veto - 1'b1];
      o_cal  <= (d_cal  == '0) ? c_cal  : h_cal[d_cal - 1'b1];
      o_nzs  <= (d_nzs  == '0) ? c_nzs  : h_nzs[d_nzs - 1'b1];
      o_snap <= (d_snap == '0) ? c_snap : h_snap[d_snap - 1'b1];
    end
  end
endmodule

// File: rtl/fe_cmd_delay_chk.sv
`timescale 1ns/1ps
module fe_cmd_delay_chk #(
  parameter int XID_W   = 12,
  parameter int CAL_W   = 4,
  parameter int MAX_DLY = 31,
  localparam int NCH    = 7,
  localparam int DW     = $clog2(MAX_DLY + 1),
  localparam int SEL_W  = $clog2(NCH + 1),
  localparam int WORD_W = XID_W + CAL_W + 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] i_word,
  input logic              cfg_we,
  input logic [SEL_W-1:0]  cfg_sel,
  input logic [DW-1:0]     cfg_val,
  input logic [NCH*DW-1:0] dly_q,
  input logic              o_xrst,
  input logic              o_frst,
  input logic              o_veto
);
  localparam int B_VETO = XID_W + CAL_W + 3;

  AST_XRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (o_xrst && !$past(cfg_we && cfg_sel == SEL_W'(0))) |=> !o_xrst); // R6
  AST_FRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (o_frst && !$past(cfg_we && cfg_sel == SEL_W'(1))) |=> !o_frst); // R6
  AST_SEL7_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_W'(7)) |=> $stable(dly_q)); // R5
  AST_DLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel < SEL_W'(NCH)) |=>
      (dly_q[$past(cfg_sel)*DW +: DW] ==
       (($past(cfg_val) > DW'(MAX_DLY)) ? DW'(MAX_DLY) : $past(cfg_val)))); // R4
  AST_VETO_ZERO_DLY: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_q[3*DW +: DW] == '0) |=> (o_veto == $past(i_word[B_VETO]))); // R2
endmodule

bind fe_cmd_delay fe_cmd_delay_chk #(
  .XID_W(XID_W), .CAL_W(CAL_W), .MAX_DLY(MAX_DLY)
) chk_i (
  .clk(clk), .rst_n(rst_n), .i_word(i_word), .cfg_we(cfg_we),
  .cfg_sel(cfg_sel), .cfg_val(cfg_val), .dly_q(dly_q),
  .o_xrst(o_xrst), .o_frst(o_frst), .o_veto(o_veto)
);

// File: tb/fe_cmd_delay_tb_top.sv
`timescale 1ns/1ps
module fe_cmd_delay_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] i_word = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [4:0]  cfg_val = '0;
  logic        o_xrst, o_frst, o_hdr, o_veto, o_nzs, o_snap;
  logic [3:0]  o_cal;
  logic [11:0] o_xid;

  int errors = 0;
  int checks = 0;
  string phase = "R2";

  logic [23:0] mh [32];
  logic [1:0]  mprev;
  int          mdly [7];
  logic [23:0] e_word [7];

  always #2.5 clk = ~clk;

  fe_cmd_delay dut_i (
    .clk(clk), .rst_n(rst_n), .i_word(i_word), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_val(cfg_val), .o_xrst(o_xrst), .o_frst(o_frst),
    .o_hdr(o_hdr), .o_veto(o_veto), .o_cal(o_cal), .o_nzs(o_nzs),
    .o_snap(o_snap), .o_xid(o_xid)
  );

  task automatic chk(input string r, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s phase) %s: actual=%0h expected=%0h", r, phase, nm, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) mh[i] = '0;
    for (int c = 0; c < 7; c++) begin mdly[c] = 0; e_word[c] = '0; end
    mprev = '0;
  endtask

  task automatic compare_all();
    chk("R6", "xrst", int'(o_xrst), int'(e_word[0][16]));
    chk("R6", "frst", int'(o_frst), int'(e_word[1][17]));
    chk("R2", "hdr",  int'(o_hdr),  int'(e_word[2][18]));
    chk("R3", "xid",  int'(o_xid),  int'(e_word[2][11:0]));
    chk("R2", "veto", int'(o_veto), int'(e_word[3][19]));
    chk("R9", "cal",  int'(o_cal),  int'(e_word[4][15:12]));
    chk("R1", "nzs",  int'(o_nzs),  int'(e_word[5][20]));
    chk("R1", "snap", int'(o_snap), int'(e_word[6][21]));
  endtask

  // drive at negedge, model at posedge, compare at the following negedge
  task automatic step(input logic [23:0] w, input logic we = 1'b0,
                      input logic [2:0] sel = '0, input logic [4:0] v = '0);
    logic [23:0] pw;
    i_word = w; cfg_we = we; cfg_sel = sel; cfg_val = v;
    @(posedge clk);
    pw = w;
    pw[16] = w[16] & ~mprev[0];
    pw[17] = w[17] & ~mprev[1];
    mprev = w[17:16];
    for (int i = 31; i > 0; i--) mh[i] = mh[i-1];
    mh[0] = pw;
    for (int c = 0; c < 7; c++) e_word[c] = mh[mdly[c]];
    if (we && sel != 3'd7) mdly[sel] = (v > 5'd31) ? 31 : int'(v);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R7: outputs held at 0 during reset even with a busy input word
    i_word = 24'hFFFFFF;
    @(negedge clk);
    phase = "R7";
    compare_all();
    rst_n = 1'b1;
    i_word = '0;

    // R7: zero history after reset, delays 0
    for (int k = 0; k < 4; k++) step('0);

    // R1, R2: all delays 0, random words
    phase = "R1";
    for (int k = 0; k < 30; k++) step(24'($urandom));

    // R4: distinct delays per channel
    phase = "R4";
    step('0, 1'b1, 3'd0, 5'd3);
    step('0, 1'b1, 3'd1, 5'd16);
    step('0, 1'b1, 3'd2, 5'd31);
    step('0, 1'b1, 3'd3, 5'd0);
    step('0, 1'b1, 3'd4, 5'd7);
    step('0, 1'b1, 3'd5, 5'd20);
    step('0, 1'b1, 3'd6, 5'd1);

    // R2, R3, R9: sparse single-event words to expose alignment
    phase = "R2";
    step(24'h3C5A7B);
    for (int k = 0; k < 35; k++) step('0);
    for (int k = 0; k < 60; k++) step(24'($urandom));

    // R6: runs of reset bits collapse to one pulse
    phase = "R6";
    for (int k = 0; k < 6; k++) step(24'h030000);
    step('0);
    step(24'h010000);
    step(24'h020000);
    step(24'h030000);
    for (int k = 0; k < 20; k++) step('0);

    // R5: selector 7 leaves all delays alone while traffic flows
    phase = "R5";
    step(24'($urandom), 1'b1, 3'd7, 5'd9);
    for (int k = 0; k < 40; k++) step(24'($urandom));

    // R4: change delays mid-stream
    phase = "R4";
    step(24'($urandom), 1'b1, 3'd2, 5'd5);
    for (int k = 0; k < 10; k++) step(24'($urandom));
    step(24'($urandom), 1'b1, 3'd0, 5'd0);
    for (int k = 0; k < 40; k++) step(24'($urandom));

    // R8: only spare bits toggle, outputs must stay quiet
    phase = "R8";
    for (int k = 0; k < 40; k++) step({2'($urandom), 22'h0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule